// File: doc/BRIEF.md
# Series Arc Event Classifier

This block sits behind a feature extractor in a low-voltage DC protection path. It receives three single-bit condition flags once per clock. The first is a transient flag, raised while high-frequency content in the line current is above its threshold. The second is an abnormal-level flag, raised while the smoothed current magnitude is below its abnormal threshold. The third is a dead-level flag, raised while that magnitude is below a near-zero threshold. From these flags the block decides whether the line is healthy, has shed load, has been switched open, or is carrying a series arc.

A genuine arc shows sustained high-frequency content together with a depressed current level. A load step or a line opening shows a level change with only a short transient. The block therefore filters the transient flag through a persistence counter before using it. It also requires the arc condition to hold for a programmable dwell time before it raises a trip request. The trip request stays latched until an external clear. The dwell time and the persistence length are parameters counted in clock ticks.

Top module: `arc_event_classifier`

## Requirements
- R1: While reset is low, and right after reset is released, `state_code` is 0 (normal) and `trip_req` is 0. Asserting reset forces this at once, without waiting for a clock.
- R2: `state_code` uses these codes: 0 normal, 1 confirming arc, 2 arc present, 3 load rejection, 4 line switching, 5 trip. No other code ever appears. `trip_req` is 1 exactly while the code is 5.
- R3: The transient flag counts as a fault indication only after it has been sampled high on PERSIST_TICKS consecutive clocks. A shorter burst changes nothing.
- R4: From normal, a high abnormal-level flag moves the state to load rejection on the next clock when the filtered transient indication is absent. It moves the state to confirming arc when the indication is present.
- R5: From confirming arc, the state moves to arc present on the next clock if the filtered transient indication and the abnormal-level flag are both still high. Otherwise it returns to normal.
- R6: Arc present moves to trip after DWELL_TICKS consecutive clocks in which both conditions stay high. If either condition drops first, the state returns to normal and the dwell count starts again from zero.
- R7: In load rejection, the filtered transient indication takes priority and moves the state to confirming arc. Otherwise, the abnormal-level flag low with the dead-level flag high moves the state to line switching. Both flags low for DWELL_TICKS consecutive clocks returns the state to normal.
- R8: Line switching returns to normal on the clock after the dead-level flag falls. It never trips.
- R9: Trip holds until `trip_clear` is sampled high, and then the state becomes normal. `trip_clear` has no effect in any other state.
- R10: In normal, the state stays normal whenever the abnormal-level flag is low, whatever the transient and dead-level flags do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| hf_flag | input | 1 | Raw transient (high-frequency) flag |
| abn_flag | input | 1 | Current level below the abnormal threshold |
| dead_flag | input | 1 | Current level below the near-zero threshold |
| trip_clear | input | 1 | Releases a latched trip |
| state_code | output | 3 | Encoded classification state |
| trip_req | output | 1 | Latched trip request |

## Verification
The assertions assume that all flag inputs are synchronous to `clk` and settle well away from its rising edge. They also assume the flags are never X after reset. The bench drives every input only on the falling edge and holds each flag pattern for a whole number of cycles. It chooses hold lengths just below and exactly at PERSIST_TICKS and DWELL_TICKS, so that each timed boundary is reached from both sides within the legal input space.

// File: rtl/arc_cls_pkg.sv
package arc_cls_pkg;
  typedef enum logic [2:0] {
    ST_NORMAL   = 3'd0,
    ST_CONFIRM  = 3'd1,
    ST_ARC      = 3'd2,
    ST_LOAD_REJ = 3'd3,
    ST_LINE_SW  = 3'd4,
    ST_TRIP     = 3'd5
  } arc_state_e;
endpackage

// File: rtl/hf_persist.sv
// Saturating run-length counter: qualifies a flag after LEN consecutive highs.
module hf_persist #(
  parameter int LEN = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic qualified
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LIM = CW'(LEN);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign qualified = (cnt_q == LIM);
  assign cnt_en    = !(raw && qualified);

  always_comb begin
    if (raw) cnt_d = cnt_q + CW'(1);
    else     cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dwell_timer.sv
// Counts consecutive cycles of 'run'; 'expire' flags the last one of TICKS.
module dwell_timer #(
  parameter int TICKS = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int CW = (TICKS > 2) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expire = run && (cnt_q == LAST);
  assign cnt_en = !expire;

  always_comb begin
    if (run) cnt_d = cnt_q + CW'(1);
    else     cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/arc_event_classifier.sv
module arc_event_classifier
  import arc_cls_pkg::*;
#(
  parameter int PERSIST_TICKS = 12,
  parameter int DWELL_TICKS   = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hf_flag,
  input  logic       abn_flag,
  input  logic       dead_flag,
  input  logic       trip_clear,
  output logic [2:0] state_code,
  output logic       trip_req
);
  arc_state_e state_q, state_d;
  logic       hf_ok;
  logic       arc_cond;
  logic       dwell_run;
  logic       dwell_done;

  hf_persist #(.LEN(PERSIST_TICKS)) u_persist (
    .clk       (clk),
    .rst_n     (rst_n),
    .raw       (hf_flag),
    .qualified (hf_ok)
  );

  assign arc_cond = hf_ok && abn_flag;

  // One timer serves both timed exits; the two states never overlap.
  assign dwell_run = ((state_q == ST_ARC) && arc_cond) ||
                     ((state_q == ST_LOAD_REJ) && !hf_ok && !abn_flag && !dead_flag);

  dwell_timer #(.TICKS(DWELL_TICKS)) u_dwell (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (dwell_run),
    .expire (dwell_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_NORMAL: begin
        if (arc_cond)      state_d = ST_CONFIRM;
        else if (abn_flag) state_d = ST_LOAD_REJ;
      end
      ST_CONFIRM: begin
        if (arc_cond) state_d = ST_ARC;
        else          state_d = ST_NORMAL;
      end
      ST_ARC: begin
        if (!arc_cond)       state_d = ST_NORMAL;
        else if (dwell_done) state_d = ST_TRIP;
      end
      ST_LOAD_REJ: begin
        if (hf_ok)                       state_d = ST_CONFIRM;
        else if (!abn_flag && dead_flag) state_d = ST_LINE_SW;
        else if (dwell_done)             state_d = ST_NORMAL;
      end
      ST_LINE_SW: begin
        if (!dead_flag) state_d = ST_NORMAL;
      end
      ST_TRIP: begin
        if (trip_clear) state_d = ST_NORMAL;
      end
      default: state_d = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_NORMAL;
    else        state_q <= state_d;
  end

  assign state_code = state_q;
  assign trip_req   = (state_q == ST_TRIP);
endmodule

// File: rtl/arc_cls_checker.sv
module arc_cls_checker
  import arc_cls_pkg::*;
#(
  parameter int DWELL_TICKS = 200
) (
  input logic       clk,
  input logic       rst_n,
  input logic       abn_flag,
  input logic       trip_clear,
  input logic [2:0] state_code,
  input logic       trip_req
);
  logic [31:0] arc_cycles;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   arc_cycles <= '0;
    else if (state_code == ST_ARC) arc_cycles <= arc_cycles + 32'd1;
    else                          arc_cycles <= '0;
  end

  p_legal_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    state_code <= 3'd5);

  p_trip_pin_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trip_req) |-> $past(state_code) == ST_ARC);

  p_trip_from_arc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == ST_TRIP && $past(state_code) != ST_TRIP) |-> $past(state_code) == ST_ARC);

  p_dwell_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == ST_ARC && arc_cycles < 32'(DWELL_TICKS - 1)) |=> state_code != ST_TRIP);

  p_line_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == ST_LINE_SW && $past(state_code) != ST_LINE_SW) |-> $past(state_code) == ST_LOAD_REJ);

  p_trip_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == ST_TRIP && !trip_clear) |=> state_code == ST_TRIP);

  p_normal_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == ST_NORMAL && !abn_flag) |=> state_code == ST_NORMAL);
endmodule

bind arc_event_classifier arc_cls_checker #(.DWELL_TICKS(DWELL_TICKS)) u_arc_cls_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .abn_flag   (abn_flag),
  .trip_clear (trip_clear),
  .state_code (state_code),
  .trip_req   (trip_req)
);

// File: tb/test_arc_event_classifier.sv
module test_arc_event_classifier;
  localparam int P = 4;
  localparam int D = 20;
  localparam int NV = 28;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hf_flag = 1'b0, abn_flag = 1'b0, dead_flag = 1'b0, trip_clear = 1'b0;
  logic [2:0] state_code;
  logic       trip_req;
  int         n_vec = 0;
  int         n_bad = 0;

  always #5 clk = ~clk;

  arc_event_classifier #(.PERSIST_TICKS(P), .DWELL_TICKS(D)) i_arc_event_classifier (
    .clk(clk), .rst_n(rst_n), .hf_flag(hf_flag), .abn_flag(abn_flag),
    .dead_flag(dead_flag), .trip_clear(trip_clear),
    .state_code(state_code), .trip_req(trip_req)
  );

  // {hf, abn, dead, clear} , hold cycles , expected code , requirement
  localparam logic [18:0] VEC [NV] = '{
    {4'b0000, 8'd3,  3'd0, 4'd10},  // R10 idle
    {4'b1000, 8'd10, 3'd0, 4'd10},  // R10 transient alone in normal
    {4'b0000, 8'd2,  3'd0, 4'd3},
    {4'b0100, 8'd1,  3'd3, 4'd4},   // R4 level drop -> load rejection
    {4'b1100, 8'd3,  3'd3, 4'd3},   // R3 burst of P-1 ignored
    {4'b0100, 8'd2,  3'd3, 4'd3},
    {4'b0000, 8'd19, 3'd3, 4'd7},   // R7 restored, dwell not over
    {4'b0000, 8'd1,  3'd0, 4'd7},   // R7 dwell over -> normal
    {4'b0100, 8'd1,  3'd3, 4'd4},
    {4'b0010, 8'd1,  3'd4, 4'd7},   // R7 dead level -> line switching
    {4'b0010, 8'd5,  3'd4, 4'd8},   // R8 holds
    {4'b0000, 8'd1,  3'd0, 4'd8},   // R8 dead falls -> normal
    {4'b1100, 8'd1,  3'd3, 4'd4},
    {4'b1100, 8'd3,  3'd3, 4'd3},   // R3 P highs counted, not yet acted on
    {4'b1100, 8'd1,  3'd1, 4'd7},   // R7 transient during load rejection
    {4'b1100, 8'd1,  3'd2, 4'd5},   // R5 confirm -> arc
    {4'b1100, 8'd10, 3'd2, 4'd6},
    {4'b1000, 8'd1,  3'd0, 4'd6},   // R6 exit before expiry
    {4'b1100, 8'd1,  3'd1, 4'd4},   // R4 both from normal -> confirm
    {4'b1100, 8'd1,  3'd2, 4'd5},
    {4'b1100, 8'd19, 3'd2, 4'd6},   // R6 dwell restarted from zero
    {4'b1100, 8'd1,  3'd5, 4'd6},   // R6 trip
    {4'b0000, 8'd5,  3'd5, 4'd9},   // R9 latched
    {4'b0001, 8'd1,  3'd0, 4'd9},   // R9 clear
    {4'b0001, 8'd2,  3'd0, 4'd9},   // R9 clear in normal ignored
    {4'b1100, 8'd5,  3'd1, 4'd5},
    {4'b1000, 8'd1,  3'd0, 4'd5},   // R5 confirm falls back
    {4'b0000, 8'd2,  3'd0, 4'd2}    // R2 final
  };

  task automatic check(input logic [2:0] exp_code, input int req);
    logic exp_trip;
    exp_trip = (exp_code == 3'd5);
    n_vec++;
    if (state_code !== exp_code || trip_req !== exp_trip) begin
      n_bad++;
      $display("FAIL R%0d: state=%0d trip=%0b expected state=%0d trip=%0b",
               req, state_code, trip_req, exp_code, exp_trip);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (R1..R10): run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(3'd0, 1);              // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    check(3'd0, 1);              // R1 after release

    for (int i = 0; i < NV; i++) begin
      {hf_flag, abn_flag, dead_flag, trip_clear} = VEC[i][18:15];
      repeat (int'(VEC[i][14:7])) @(negedge clk);
      check(VEC[i][6:4], int'(VEC[i][3:0]));
    end

    // R1: asynchronous reset from a non-normal state
    {hf_flag, abn_flag, dead_flag, trip_clear} = 4'b0100;
    repeat (2) @(negedge clk);
    check(3'd3, 4);
    #2 rst_n = 1'b0;
    #1 check(3'd0, 1);
    @(negedge clk);
    rst_n = 1'b1;
    {hf_flag, abn_flag, dead_flag, trip_clear} = 4'b0000;
    @(negedge clk);
    check(3'd0, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule